// File: doc/BRIEF.md
# Sharer Directory for a Shared Second-Level Cache Bank

This block is the coherence directory that sits beside one bank of a shared second-level cache. Eight cores sit above that bank, and each core has a private first-level data cache that writes through. For every line slot in the bank, the directory keeps one bit per core. A set bit means that core's first-level cache may hold a copy of the line. The directory lives at the second-level cache and not at memory because every first-level line is also held in the second level. Writes always go through to the second level, so coherence only ever needs invalidations: there is no ownership state and no writeback.

The request port takes three kinds of request, each with a core number and a line slot index: a load miss, a store, and an eviction from the second level. The tag lookup upstream has already resolved the slot index. A load miss marks the requester as a sharer. A store invalidates every other sharer and leaves the line with no sharers at all. An eviction invalidates every sharer. Invalidations leave on a valid/ready port, one core per transfer, lowest core number first. The request port stalls until the last invalidation has been taken.

Top module: `sharer_dir`

## Requirements
- R1: After reset, every sharer vector is empty, `req_ready` is 1 and `inv_valid` is 0. An eviction of any slot after reset produces no invalidation.
- R2: An accepted load miss (`req_op` = 0) sets the requester's bit in that slot's vector and produces no invalidation.
- R3: An accepted store (`req_op` = 1) produces one invalidation for each set bit of the slot's vector other than the writer's own bit. A store never sets the writer's bit.
- R4: After an accepted store, the slot's vector is empty, and this includes the writer's bit.
- R5: An accepted eviction (`req_op` = 2) produces one invalidation for each set bit of the slot's vector and then leaves the vector empty.
- R6: The invalidations for one request are presented in strictly ascending core number. With `inv_ready` held at 1, one is transferred every cycle, and the first is valid in the cycle after the request is accepted.
- R7: While `inv_valid` is 1 and `inv_ready` is 0, `inv_valid`, `inv_core` and `inv_idx` hold their values.
- R8: `req_ready` is 0 while any invalidation is pending. A request presented during that time is ignored.
- R9: An accepted request with `req_op` = 3 changes no vector and produces no invalidation.
- R10: A request changes only the vector of its own slot.
- R11: Each invalidation carries, on `inv_idx`, the slot index of the request that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The directory can take a request this cycle |
| req_op | input | 2 | 0 load miss, 1 store, 2 eviction, 3 no operation |
| req_core | input | CORE_W (3) | Core that issued the request |
| req_idx | input | IDX_W (6) | Line slot index in the bank |
| inv_valid | output | 1 | An invalidation is presented |
| inv_ready | input | 1 | The receiver takes the invalidation |
| inv_core | output | CORE_W (3) | Core whose first-level copy must be dropped |
| inv_idx | output | IDX_W (6) | Line slot index being invalidated |

## Verification
A request is accepted at a rising edge. Its first invalidation is visible one cycle later, and while `inv_ready` stays high each following invalidation appears one cycle after the one before. The bench therefore drives a request at a falling edge, lets one rising edge pass, and then reads `inv_valid` at each following falling edge until it drops. It collects the core numbers into a mask and checks their order and slot index as they arrive. Vector updates are not visible directly, so they are checked one request later: a later store or eviction on the same slot has to produce exactly the invalidations that the earlier requests imply.

// File: rtl/sdir_pkg.sv
package sdir_pkg;

    // Request operation codes; values are fixed by the port contract.
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_EVICT = 2'd2,
        OP_NOP   = 2'd3
    } sdir_op_e;

endpackage

// File: rtl/sdir_vec_store.sv
// Per-slot sharer vectors: combinational read, one write per cycle.
module sdir_vec_store #(
    parameter int CORES = 8,
    parameter int LINES = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CORES-1:0] rd_vec,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CORES-1:0] wr_vec
);

    typedef logic [CORES-1:0] vec_t;

    typedef struct packed {
        vec_t [LINES-1:0] line;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.line[wr_idx] = wr_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_vec = st_q.line[rd_idx];

endmodule

// File: rtl/sdir_lowest.sv
// Index of the lowest set bit of a vector.
module sdir_lowest #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] pos,
    output logic         found
);

    always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                pos   = W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdir_inv_sched.sv
// Holds the pending invalidation targets and issues them lowest core first.
module sdir_inv_sched #(
    parameter int CORES  = 8,
    parameter int CORE_W = 3,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [CORES-1:0]  load_vec,
    input  logic [IDX_W-1:0]  load_idx,
    output logic              busy,
    output logic              inv_valid,
    input  logic              inv_ready,
    output logic [CORE_W-1:0] inv_core,
    output logic [IDX_W-1:0]  inv_idx
);

    typedef struct packed {
        logic [CORES-1:0] pend;
        logic [IDX_W-1:0] idx;
    } sched_t;

    sched_t sc_d, sc_q;

    logic [CORE_W-1:0] pick;
    logic              any;

    sdir_lowest #(.N(CORES), .W(CORE_W)) u_pick (
        .vec   (sc_q.pend),
        .pos   (pick),
        .found (any)
    );

    always_comb begin
        sc_d = sc_q;
        if (any && inv_ready) begin
            sc_d.pend[pick] = 1'b0;
        end
        if (load_en) begin
            sc_d.pend = load_vec;
            sc_d.idx  = load_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_q <= '0;
        end else begin
            sc_q <= sc_d;
        end
    end

    assign busy      = any;
    assign inv_valid = any;
    assign inv_core  = pick;
    assign inv_idx   = sc_q.idx;

endmodule

// File: rtl/sharer_dir.sv
// Sharer directory for one shared cache bank.
module sharer_dir
    import sdir_pkg::*;
#(
    parameter int CORES  = 8,
    parameter int LINES  = 64,
    parameter int CORE_W = $clog2(CORES),
    parameter int IDX_W  = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [CORE_W-1:0] req_core,
    input  logic [IDX_W-1:0]  req_idx,
    output logic              inv_valid,
    input  logic              inv_ready,
    output logic [CORE_W-1:0] inv_core,
    output logic [IDX_W-1:0]  inv_idx
);

    logic [CORES-1:0] cur_vec;
    logic [CORES-1:0] self_bit;
    logic             busy;
    logic             accept;
    logic             wr_en;
    logic [CORES-1:0] wr_vec;
    logic             ld_en;
    logic [CORES-1:0] ld_vec;
    sdir_op_e         op;

    assign op       = sdir_op_e'(req_op);
    assign accept   = req_valid && !busy;
    assign self_bit = {{(CORES-1){1'b0}}, 1'b1} << req_core;

    sdir_vec_store #(.CORES(CORES), .LINES(LINES), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (req_idx),
        .rd_vec (cur_vec),
        .wr_en  (wr_en),
        .wr_idx (req_idx),
        .wr_vec (wr_vec)
    );

    always_comb begin
        wr_en  = 1'b0;
        wr_vec = cur_vec;
        ld_en  = 1'b0;
        ld_vec = '0;
        if (accept) begin
            unique case (op)
                OP_LOAD: begin
                    wr_en  = 1'b1;
                    wr_vec = cur_vec | self_bit;
                end
                OP_STORE: begin
                    wr_en  = 1'b1;
                    wr_vec = '0;
                    ld_en  = 1'b1;
                    ld_vec = cur_vec & ~self_bit;
                end
                OP_EVICT: begin
                    wr_en  = 1'b1;
                    wr_vec = '0;
                    ld_en  = 1'b1;
                    ld_vec = cur_vec;
                end
                default: begin
                end
            endcase
        end
    end

    sdir_inv_sched #(.CORES(CORES), .CORE_W(CORE_W), .IDX_W(IDX_W)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (ld_en),
        .load_vec  (ld_vec),
        .load_idx  (req_idx),
        .busy      (busy),
        .inv_valid (inv_valid),
        .inv_ready (inv_ready),
        .inv_core  (inv_core),
        .inv_idx   (inv_idx)
    );

    assign req_ready = !busy;

endmodule

// File: rtl/sharer_dir_chk.sv
module sharer_dir_chk #(
    parameter int CORE_W = 3,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic [CORE_W-1:0] req_core,
    input logic [IDX_W-1:0]  req_idx,
    input logic              inv_valid,
    input logic              inv_ready,
    input logic [CORE_W-1:0] inv_core,
    input logic [IDX_W-1:0]  inv_idx
);

    logic acc;
    assign acc = req_valid && req_ready;

    a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && !inv_ready |=> inv_valid && $stable(inv_core) && $stable(inv_idx));

    a_r6_ascending_order: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && inv_ready |=> !inv_valid || (inv_core > $past(inv_core)));

    a_r2_load_no_inval: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_op == 2'd0 |=> !inv_valid);

    a_r3_writer_skipped: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_op == 2'd1 |=> !inv_valid || inv_core != $past(req_core));

    a_r8_stall_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> !req_ready);

    a_r11_slot_carried: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_op == 2'd2 |=> !inv_valid || inv_idx == $past(req_idx));

    a_r9_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_op == 2'd3 |=> !inv_valid);

endmodule

bind sharer_dir sharer_dir_chk #(.CORE_W(CORE_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_core  (req_core),
    .req_idx   (req_idx),
    .inv_valid (inv_valid),
    .inv_ready (inv_ready),
    .inv_core  (inv_core),
    .inv_idx   (inv_idx)
);

// File: tb/sharer_dir_tb.sv
`timescale 1ns/1ps
module sharer_dir_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_op = 2'd0;
    logic [2:0] req_core = 3'd0;
    logic [5:0] req_idx = 6'd0;
    logic       inv_valid;
    logic       inv_ready = 1'b1;
    logic [2:0] inv_core;
    logic [5:0] inv_idx;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sharer_dir u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_core  (req_core),
        .req_idx   (req_idx),
        .inv_valid (inv_valid),
        .inv_ready (inv_ready),
        .inv_core  (inv_core),
        .inv_idx   (inv_idx)
    );

    // {op[1:0], core[2:0], idx[5:0], expected invalidation mask[7:0]}
    localparam int NV = 21;
    localparam logic [18:0] VEC [NV] = '{
        {2'd2, 3'd0, 6'd5,  8'h00},  // R1 empty after reset
        {2'd0, 3'd1, 6'd5,  8'h00},  // R2
        {2'd0, 3'd3, 6'd5,  8'h00},
        {2'd0, 3'd6, 6'd5,  8'h00},
        {2'd0, 3'd2, 6'd9,  8'h00},
        {2'd1, 3'd3, 6'd5,  8'h42},  // R3 cores 1,6, writer 3 skipped
        {2'd2, 3'd0, 6'd5,  8'h00},  // R4 writer bit cleared
        {2'd0, 3'd0, 6'd5,  8'h00},
        {2'd0, 3'd7, 6'd5,  8'h00},
        {2'd0, 3'd4, 6'd5,  8'h00},
        {2'd3, 3'd5, 6'd5,  8'h00},  // R9 no effect
        {2'd2, 3'd2, 6'd5,  8'h91},  // R5 cores 0,4,7; no 5
        {2'd2, 3'd0, 6'd5,  8'h00},  // R5 cleared
        {2'd2, 3'd0, 6'd9,  8'h04},  // R10 slot 9 untouched by slot 5
        {2'd0, 3'd5, 6'd12, 8'h00},
        {2'd1, 3'd5, 6'd12, 8'h00},  // R3 sole sharer writes
        {2'd2, 3'd0, 6'd12, 8'h00},  // R4
        {2'd0, 3'd2, 6'd63, 8'h00},
        {2'd0, 3'd5, 6'd63, 8'h00},
        {2'd1, 3'd0, 6'd63, 8'h24},  // R3 writer not a sharer
        {2'd2, 3'd0, 6'd63, 8'h00}   // R4
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'd0:    return "R2 load";
            2'd1:    return "R3 store";
            2'd2:    return "R5 evict";
            default: return "R9 nop";
        endcase
    endfunction

    // Reads invalidations at falling edges with inv_ready high until none is left.
    task automatic collect(input logic [5:0] idx, input logic [7:0] exp, input string tag);
        logic [7:0] mask = '0;
        int last = -1;
        int n = 0;
        while (inv_valid && n < 16) begin
            chk(inv_idx == idx, "R11 slot index", int'(inv_idx), int'(idx));
            chk(int'(inv_core) > last, "R6 ascending order", int'(inv_core), last + 1);
            chk(!req_ready, "R8 ready low while pending", int'(req_ready), 0);
            mask[inv_core] = 1'b1;
            last = int'(inv_core);
            n++;
            @(negedge clk);
        end
        chk(mask == exp, tag, int'(mask), int'(exp));
        chk(req_ready, "R8 ready back after drain", int'(req_ready), 1);
    endtask

    task automatic issue(input logic [1:0] op, input logic [2:0] core, input logic [5:0] idx);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_core  = core;
        req_idx   = idx;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_req(input logic [1:0] op, input logic [2:0] core,
                           input logic [5:0] idx, input logic [7:0] exp, input string tag);
        issue(op, core, idx);
        collect(idx, exp, tag);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000 && !done) begin
            done = 1'b1;
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset outputs
        chk(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
        chk(inv_valid == 1'b0, "R1 inv_valid after reset", int'(inv_valid), 0);

        for (int k = 0; k < NV; k++) begin
            logic [18:0] v;
            v = VEC[k];
            run_req(v[18:17], v[16:14], v[13:8], v[7:0], op_tag(v[18:17]));
        end

        // R7 and R8: back-pressure on invalidations, request during stall ignored
        run_req(2'd0, 3'd1, 6'd20, 8'h00, "R2 load");
        run_req(2'd0, 3'd4, 6'd20, 8'h00, "R2 load");
        inv_ready = 1'b0;
        issue(2'd2, 3'd0, 6'd20);
        req_valid = 1'b1;
        req_op    = 2'd0;
        req_core  = 3'd7;
        req_idx   = 6'd20;
        for (int c = 0; c < 3; c++) begin
            chk(inv_valid && inv_core == 3'd1, "R7 hold core under stall", int'(inv_core), 1);
            chk(inv_idx == 6'd20, "R7 hold slot under stall", int'(inv_idx), 20);
            chk(!req_ready, "R8 ready low during stall", int'(req_ready), 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        inv_ready = 1'b1;
        collect(6'd20, 8'h12, "R5 evict after stall");
        run_req(2'd2, 3'd0, 6'd20, 8'h00, "R8 stalled load ignored");

        // R1 mid-run reset clears vectors
        run_req(2'd0, 3'd3, 6'd30, 8'h00, "R2 load");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_req(2'd2, 3'd0, 6'd30, 8'h00, "R1 vectors cleared by reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule